// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a PCI-like interconnect and turns two processor-visible registers into configuration-space transactions. The first register is a 32-bit address latch. Software writes the enable bit, the bus number, the device/function number and the register offset into it. The second register is a data window. Each read or write of the window becomes one configuration request. The latched address selects the target, and the low two bits of the window offset choose the byte lane.

Processor accesses arrive on a simple register bus. Each access carries a port select, a byte offset and a byte count. The access is held until the bridge pulses its completion flag. Data-window accesses are forwarded over a valid/ready request channel to the configuration fabric, and the bridge waits for the response. A response whose present flag is low means no device answered, and a read of it returns all ones. The forwarded length is cut so that no request runs past the end of configuration space.

Top module: `cfgport_bridge`

## Requirements
- R1: `hst_sel`=0 selects the address port and 1 selects the data window. The address latch is loaded from `hst_wdata` only by a write with `hst_off`=0 and `hst_len`=4. Any other write to the address port leaves the latch unchanged.
- R2: A read of the address port returns the whole 32-bit latch, whatever `hst_off` and `hst_len` are.
- R3: The latch resets to zero. While latch bit 31 is clear, a data-window write completes without issuing a request, and a data-window read completes with 0xFFFFFFFF and issues no request.
- R4: A forwarded request carries the bus number from latch bits 23:16 and the device/function number from latch bits 15:8. Its register offset is (latch bits 7:0 OR `hst_off`) masked to `CFG_SPACE`-1. The two values are ORed, not added.
- R5: The forwarded length (a byte count) is the requested length, saturated at 4, then cut to the bytes that remain before `CFG_SPACE`.
- R6: When the response has `cfg_rsp_present`=0, a read completes with 0xFFFFFFFF and a write completes with no further effect.
- R7: When the response has `cfg_rsp_present`=1, a read returns `cfg_rsp_rdata` unchanged, right-justified as the fabric supplies it. A write forwards `hst_wdata` and sets `cfg_req_write`.
- R8: A request holds its fields stable until `cfg_req_ready`. `hst_ready` is a single-cycle pulse, and for an enabled data access it comes only after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_valid | input | 1 | Host access pending, held until `hst_ready` |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_sel | input | 1 | 0 = address port, 1 = data window |
| hst_off | input | 2 | Byte offset within the selected port |
| hst_len | input | 3 | Access size in bytes |
| hst_wdata | input | 32 | Write data, right-justified |
| hst_ready | output | 1 | Completion pulse, with read data valid |
| hst_rdata | output | 32 | Read data |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Fabric accepts the request |
| cfg_req_write | output | 1 | Request is a write |
| cfg_req_bus | output | 8 | Target bus number |
| cfg_req_devfn | output | 8 | Target device/function |
| cfg_req_off | output | $clog2(CFG_SPACE) | Register offset |
| cfg_req_len | output | 3 | Clamped byte count |
| cfg_req_wdata | output | 32 | Write data |
| cfg_rsp_valid | input | 1 | Response strobe |
| cfg_rsp_present | input | 1 | A device answered |
| cfg_rsp_rdata | input | 32 | Response read data, right-justified |

## Verification
The bench builds the bridge with `CFG_SPACE`=256, so the register offset is the full eight-bit field and the length clamp acts in the last three bytes of the space. This setting lets latched offsets 0xFC to 0xFF, combined with each window lane, reach clamped lengths of 3, 2 and 1. The OR-merge is exercised with an offset that already has lane bits set. The bench's fabric model answers for two bus/function pairs and reports absent for the rest, so both the present and absent response paths are covered.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int DATA_W  = 32;
  localparam int EN_BIT  = 31;
  localparam int MAX_LEN = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP, ST_DONE} cfg_st_t;

  typedef struct packed {
    logic              write;
    logic [7:0]        bus;
    logic [7:0]        devfn;
    logic [7:0]        off;
    logic [2:0]        len;
    logic [DATA_W-1:0] wdata;
  } cfg_req_t;

  // lane bits are ORed into the latched offset, then masked to the space
  function automatic logic [7:0] merge_off(logic [7:0] base, logic [1:0] lane, int space);
    return (base | {6'b0, lane}) & 8'(space - 1);
  endfunction

  function automatic logic [2:0] sat_len(logic [2:0] l);
    return (l > 3'(MAX_LEN)) ? 3'(MAX_LEN) : l;
  endfunction

  // bytes that fit before the end of configuration space
  function automatic logic [2:0] fit_len(logic [7:0] off, logic [2:0] l, int space);
    logic [9:0] room;
    room = 10'(space) - {2'b0, off};
    if (room < {7'b0, sat_len(l)}) return room[2:0];
    return sat_len(l);
  endfunction

endpackage

// File: rtl/cfgport_latch.sv
module cfgport_latch
  import cfgport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we) |-> q == $past(wdata)); // R1
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R1

endmodule

// File: rtl/cfgport_target.sv
module cfgport_target
  import cfgport_pkg::*;
#(
  parameter int CFG_SPACE = 256
)(
  input  logic [23:0]       lat_lo,
  input  logic [1:0]        lane,
  input  logic [2:0]        len,
  input  logic              write,
  input  logic [DATA_W-1:0] wdata,
  output cfg_req_t          tgt
);

  logic [7:0] off_m;

  always_comb begin
    off_m     = merge_off(lat_lo[7:0], lane, CFG_SPACE);
    tgt.write = write;
    tgt.bus   = lat_lo[23:16];
    tgt.devfn = lat_lo[15:8];
    tgt.off   = off_m;
    tgt.len   = fit_len(off_m, len, CFG_SPACE);
    tgt.wdata = wdata;
  end

endmodule

// File: rtl/cfgport_seq.sv
module cfgport_seq
  import cfgport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_valid,
  input  logic              hst_write,
  input  logic              hst_sel,
  input  logic [1:0]        hst_off,
  input  logic [2:0]        hst_len,
  input  logic [DATA_W-1:0] lat_q,
  input  cfg_req_t          tgt,
  output logic              lat_we,
  output logic              hst_ready,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              req_valid,
  output cfg_req_t          req_q,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_present,
  input  logic [DATA_W-1:0] rsp_rdata
);

  cfg_st_t           st;
  logic [DATA_W-1:0] rdata_q;
  logic              idle_take;
  logic              rsp_take;
  logic              en;

  assign en        = lat_q[EN_BIT];
  assign idle_take = (st == ST_IDLE) && hst_valid;
  assign rsp_take  = (st == ST_RSP) && rsp_valid;
  assign lat_we    = idle_take && !hst_sel && hst_write &&
                     (hst_off == 2'd0) && (hst_len == 3'(MAX_LEN));
  assign req_valid = (st == ST_REQ);
  assign hst_ready = (st == ST_DONE);
  assign hst_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      rdata_q <= '0;
      req_q   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (hst_valid) begin
          if (!hst_sel) begin
            rdata_q <= lat_q;
            st      <= ST_DONE;
          end else if (!en) begin
            rdata_q <= '1;
            st      <= ST_DONE;
          end else begin
            req_q <= tgt;
            st    <= ST_REQ;
          end
        end
        ST_REQ:  if (req_ready) st <= ST_RSP;
        ST_RSP:  if (rsp_valid) begin
          rdata_q <= rsp_present ? rsp_rdata : '1;
          st      <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_q)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hst_ready |=> !hst_ready); // R8
  AST_ABSENT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && !rsp_present |=> hst_ready && hst_rdata == '1); // R6
  AST_DIS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    idle_take && hst_sel && !en |=> !req_valid && hst_rdata == '1); // R3

endmodule

// File: rtl/cfgport_bridge.sv
module cfgport_bridge
  import cfgport_pkg::*;
#(
  parameter int CFG_SPACE = 256,
  localparam int OFF_W = $clog2(CFG_SPACE)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_valid,
  input  logic              hst_write,
  input  logic              hst_sel,
  input  logic [1:0]        hst_off,
  input  logic [2:0]        hst_len,
  input  logic [31:0]       hst_wdata,
  output logic              hst_ready,
  output logic [31:0]       hst_rdata,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic              cfg_req_write,
  output logic [7:0]        cfg_req_bus,
  output logic [7:0]        cfg_req_devfn,
  output logic [OFF_W-1:0]  cfg_req_off,
  output logic [2:0]        cfg_req_len,
  output logic [31:0]       cfg_req_wdata,
  input  logic              cfg_rsp_valid,
  input  logic              cfg_rsp_present,
  input  logic [31:0]       cfg_rsp_rdata
);

  logic [DATA_W-1:0] lat_q;
  logic              lat_we;
  cfg_req_t          tgt;
  cfg_req_t          req_q;

  cfgport_latch u_latch (
    .clk(clk), .rst_n(rst_n), .we(lat_we), .wdata(hst_wdata), .q(lat_q)
  );

  cfgport_target #(.CFG_SPACE(CFG_SPACE)) u_target (
    .lat_lo(lat_q[23:0]), .lane(hst_off), .len(hst_len),
    .write(hst_write), .wdata(hst_wdata), .tgt(tgt)
  );

  cfgport_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .hst_valid(hst_valid), .hst_write(hst_write), .hst_sel(hst_sel),
    .hst_off(hst_off), .hst_len(hst_len),
    .lat_q(lat_q), .tgt(tgt), .lat_we(lat_we),
    .hst_ready(hst_ready), .hst_rdata(hst_rdata),
    .req_valid(cfg_req_valid), .req_q(req_q), .req_ready(cfg_req_ready),
    .rsp_valid(cfg_rsp_valid), .rsp_present(cfg_rsp_present),
    .rsp_rdata(cfg_rsp_rdata)
  );

  assign cfg_req_write = req_q.write;
  assign cfg_req_bus   = req_q.bus;
  assign cfg_req_devfn = req_q.devfn;
  assign cfg_req_off   = req_q.off[OFF_W-1:0];
  assign cfg_req_len   = req_q.len;
  assign cfg_req_wdata = req_q.wdata;

  AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> lat_q[EN_BIT]); // R3
  AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (cfg_req_len <= 3'(MAX_LEN)) &&
      (int'(cfg_req_off) + int'(cfg_req_len) <= CFG_SPACE)); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !cfg_req_valid && !hst_ready && lat_q == '0); // R3

endmodule

// File: tb/sim_cfgport_bridge.sv
module sim_cfgport_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_valid = 1'b0, hst_write = 1'b0, hst_sel = 1'b0;
  logic [1:0]  hst_off = '0;
  logic [2:0]  hst_len = '0;
  logic [31:0] hst_wdata = '0;
  logic        hst_ready;
  logic [31:0] hst_rdata;
  logic        cfg_req_valid, cfg_req_write;
  logic        cfg_req_ready = 1'b0;
  logic [7:0]  cfg_req_bus, cfg_req_devfn, cfg_req_off;
  logic [2:0]  cfg_req_len;
  logic [31:0] cfg_req_wdata;
  logic        cfg_rsp_valid = 1'b0, cfg_rsp_present = 1'b0;
  logic [31:0] cfg_rsp_rdata = '0;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  cfgport_bridge #(.CFG_SPACE(256)) u0 (.*);

  // fabric model
  logic [7:0]  m_bus, m_devfn, m_off;
  logic [2:0]  m_len;
  logic        m_wr, pend = 1'b0;
  logic [31:0] m_wd;
  int          req_count = 0, rsp_count = 0;

  function automatic logic present_at(logic [7:0] b, logic [7:0] d);
    return (b == 8'h00 && d == 8'h10) || (b == 8'h02 && d == 8'h21);
  endfunction

  function automatic logic [31:0] pat(logic [7:0] b, logic [7:0] d, logic [7:0] o, logic [2:0] l);
    logic [31:0] full = {8'hC3 ^ b, d, o, 8'h5A};
    if (l >= 3'd4) return full;
    return full & ((32'd1 << (8 * l)) - 32'd1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cfg_req_ready <= 1'b0; pend <= 1'b0; cfg_rsp_valid <= 1'b0;
    end else begin
      cfg_req_ready <= 1'b0;
      cfg_rsp_valid <= 1'b0;
      if (cfg_req_valid && !cfg_req_ready && !pend) cfg_req_ready <= 1'b1;
      if (cfg_req_valid && cfg_req_ready) begin
        m_bus <= cfg_req_bus; m_devfn <= cfg_req_devfn; m_off <= cfg_req_off;
        m_len <= cfg_req_len; m_wr <= cfg_req_write; m_wd <= cfg_req_wdata;
        pend <= 1'b1;
        req_count <= req_count + 1;
      end
      if (pend) begin
        cfg_rsp_valid   <= 1'b1;
        cfg_rsp_present <= present_at(m_bus, m_devfn);
        cfg_rsp_rdata   <= pat(m_bus, m_devfn, m_off, m_len);
        rsp_count       <= rsp_count + 1;
        pend            <= 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic sel, input logic [1:0] off,
                        input logic [2:0] len, input logic [31:0] wd,
                        output logic [31:0] rd);
    @(negedge clk);
    hst_valid = 1'b1; hst_write = wr; hst_sel = sel;
    hst_off = off; hst_len = len; hst_wdata = wd;
    do @(negedge clk); while (!hst_ready);
    rd = hst_rdata;
    hst_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] lat;
    logic [1:0]  off;
    logic [2:0]  len;
    logic [7:0]  xoff;
    logic [2:0]  xlen;
    logic        xpres;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{32'h8000_1000, 2'd0, 3'd4, 8'h00, 3'd4, 1'b1},
    '{32'h8000_1004, 2'd2, 3'd2, 8'h06, 3'd2, 1'b1},
    '{32'h8000_10FC, 2'd1, 3'd4, 8'hFD, 3'd3, 1'b1},
    '{32'h8000_10FF, 2'd0, 3'd4, 8'hFF, 3'd1, 1'b1},
    '{32'h8000_10FE, 2'd3, 3'd1, 8'hFF, 3'd1, 1'b1},
    '{32'h8002_2140, 2'd0, 3'd4, 8'h40, 3'd4, 1'b1},
    '{32'h8003_0000, 2'd0, 3'd4, 8'h00, 3'd4, 1'b0},
    '{32'h8000_10F8, 2'd0, 3'd6, 8'hF8, 3'd4, 1'b1},
    '{32'h8000_1003, 2'd1, 3'd1, 8'h03, 3'd1, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int rq0, rs0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset ready", {31'b0, hst_ready}, 32'd0);
    chk("R3 reset req_valid", {31'b0, cfg_req_valid}, 32'd0);
    access(1'b0, 1'b0, 2'd0, 3'd4, '0, rd);
    chk("R3 latch after reset", rd, 32'h0);
    rq0 = req_count;
    access(1'b0, 1'b1, 2'd0, 3'd4, '0, rd);
    chk("R3 disabled read", rd, 32'hFFFF_FFFF);
    access(1'b1, 1'b1, 2'd0, 3'd4, 32'hDEAD_BEEF, rd);
    repeat (4) @(negedge clk);
    chk("R3 disabled no request", req_count, rq0);

    for (int i = 0; i < NV; i++) begin
      access(1'b1, 1'b0, 2'd0, 3'd4, VEC[i].lat, rd);
      rs0 = rsp_count;
      access(1'b0, 1'b1, VEC[i].off, VEC[i].len, '0, rd);
      chk("R4 bus", m_bus, VEC[i].lat[23:16]);
      chk("R4 devfn", m_devfn, VEC[i].lat[15:8]);
      chk("R4 offset", m_off, VEC[i].xoff);
      chk("R5 length", m_len, VEC[i].xlen);
      chk("R8 response before ready", rsp_count, rs0 + 1);
      if (VEC[i].xpres)
        chk("R7 present read", rd, pat(VEC[i].lat[23:16], VEC[i].lat[15:8], VEC[i].xoff, VEC[i].xlen));
      else
        chk("R6 absent read", rd, 32'hFFFF_FFFF);
    end

    access(1'b1, 1'b0, 2'd0, 3'd4, 32'h8000_1010, rd);
    access(1'b1, 1'b0, 2'd1, 3'd4, 32'h1234_5678, rd);
    access(1'b0, 1'b0, 2'd0, 3'd4, '0, rd);
    chk("R1 offset write ignored", rd, 32'h8000_1010);
    access(1'b1, 1'b0, 2'd0, 3'd2, 32'h0000_5678, rd);
    access(1'b0, 1'b0, 2'd2, 3'd1, '0, rd);
    chk("R1 short write ignored", rd, 32'h8000_1010);
    chk("R2 partial read full latch", rd, 32'h8000_1010);

    rq0 = req_count;
    access(1'b1, 1'b1, 2'd1, 3'd2, 32'h0000_BEEF, rd);
    chk("R7 write flag", {31'b0, m_wr}, 32'd1);
    chk("R7 write data", m_wd, 32'h0000_BEEF);
    chk("R4 write offset", m_off, 8'h11);
    chk("R5 write length", m_len, 3'd2);
    chk("R7 write request count", req_count, rq0 + 1);

    access(1'b1, 1'b0, 2'd0, 3'd4, 32'h8003_0000, rd);
    rq0 = req_count;
    access(1'b1, 1'b1, 2'd0, 3'd4, 32'h0BAD_0BAD, rd);
    chk("R6 absent write completes", req_count, rq0 + 1);

    access(1'b1, 1'b0, 2'd0, 3'd4, 32'h0000_1010, rd);
    rq0 = req_count;
    access(1'b0, 1'b1, 2'd0, 3'd4, '0, rd);
    chk("R3 cleared enable read", rd, 32'hFFFF_FFFF);
    chk("R3 cleared enable no request", req_count, rq0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule